// File: doc/BRIEF.md
# Iterative Newton Square-Root Unit

This block finds the square root of an unsigned 16-bit integer. It applies the Newton–Raphson recurrence a fixed number of times, and one clocked state machine steps through the whole computation. The result is a 32-bit unsigned fixed-point word with 6 fractional bits, so the root equals the result divided by 64. Each division in the recurrence runs on an internal restoring divider. The divider produces one quotient bit per clock, which keeps long combinational divide chains out of every single cycle.

The block is driven by one level signal, `run_en`. While `run_en` is low the block is held in reset on the clock edge. When `run_en` is high and no result is pending, the block captures `rad_in` and starts. When the result is ready, `root_valid` rises and the result stays on `root_out` until `run_en` is dropped.

States and transitions:

| State | Transition |
|---|---|
| IDLE | Goes to LOAD when `run_en` is high. The input is captured on that edge. |
| LOAD | Places the first estimate. Goes to FINISH for a zero input, otherwise to KICK. |
| KICK | Pulses the divider start. Goes to WAIT. |
| WAIT | Stays until the divider reports done. The estimate is then updated. Goes back to KICK, or to FINISH after the last pass. |
| FINISH | Publishes the estimate. Goes to HOLD. |
| HOLD | Stays there while `run_en` is high. |

When `run_en` is low at any edge, the block returns to IDLE from every state.

Top module: `nsqrt_top`

## Requirements
- R1: For a nonzero input N, the published `root_out` equals floor(sqrt(N)·64) or that value plus one.
- R2: The input is sampled only on the start edge. Changes on `rad_in` during the computation do not affect the result.
- R3: An input of 0 skips division and publishes `root_out` = 0, with `root_valid` high 2 rising edges after the start edge.
- R4: The recurrence runs exactly 10 passes. For a nonzero input, `root_valid` rises exactly 342 rising edges after the start edge.
- R5: `root_valid` is low from the start edge until the result is published.
- R6: After publication, `root_valid` and `root_out` hold their values while `run_en` stays high, whatever `rad_in` does. No new computation starts in this period.
- R7: A low `run_en` at a rising edge clears `root_valid` and `root_out` to 0 and aborts any computation in progress.
- R8: Each division takes 34 cycles of the pass: one start cycle, 32 one-bit steps, and one update cycle. A start pulse only reaches an idle divider.
- R9: A published `root_out` never exceeds 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| run_en | input | 1 | High: start or hold. Low: synchronous reset to idle |
| rad_in | input | 16 | Unsigned integer radicand |
| root_out | output | 32 | Root in unsigned fixed point, 6 fractional bits |
| root_valid | output | 1 | High while `root_out` holds a finished result |

## Verification
The bench tests the following inputs:
- **Zero:** exercises the bypass path and its short latency.
- **1 to 4:** small values, where the truncated recurrence settles within a few passes.
- **65535 and nearby:** the largest start estimates, which need the most halving passes.
- **Perfect squares and their neighbours:** separate an exact root from an off-by-one truncation.
- **Scattered values:** cover the general range.

Further runs toggle `rad_in` during a computation or after a result, and drop `run_en` partway through, to show that sampling, holding and abort behave correctly.

// File: rtl/nsqrt_pkg.sv
package nsqrt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_KICK,
        ST_WAIT,
        ST_FINISH,
        ST_HOLD
    } nsqrt_state_e;

endpackage

// File: rtl/nsqrt_divider.sv
// Restoring shift-and-subtract divider, one quotient bit per clock.
module nsqrt_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         busy,
    output logic         done
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;

    logic [W:0]    shifted;
    logic [W:0]    trial;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                den_q  <= divisor;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
    assign busy     = busy_q;
    assign done     = done_q;

endmodule

// File: rtl/nsqrt_ctrl.sv
// Sequencer: state register, next-state logic and strobe decoding.
module nsqrt_ctrl
    import nsqrt_pkg::*;
(
    input  logic         clk,
    input  logic         run_en,
    input  logic         rad_zero,
    input  logic         div_done,
    input  logic         last_pass,
    output nsqrt_state_e state,
    output logic         cap_input,
    output logic         init_est,
    output logic         div_go,
    output logic         upd_est,
    output logic         publish
);
    nsqrt_state_e state_q;
    nsqrt_state_e state_d;

    always_ff @(posedge clk) begin
        if (!run_en) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_LOAD;
            ST_LOAD:   state_d = rad_zero ? ST_FINISH : ST_KICK;
            ST_KICK:   state_d = ST_WAIT;
            ST_WAIT: begin
                if (div_done) begin
                    state_d = last_pass ? ST_FINISH : ST_KICK;
                end
            end
            ST_FINISH: state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_HOLD;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_input = 1'b0;
        init_est  = 1'b0;
        div_go    = 1'b0;
        upd_est   = 1'b0;
        publish   = 1'b0;
        unique case (state_q)
            ST_IDLE:   cap_input = 1'b1;
            ST_LOAD:   init_est  = 1'b1;
            ST_KICK:   div_go    = 1'b1;
            ST_WAIT:   upd_est   = div_done;
            ST_FINISH: publish   = 1'b1;
            ST_HOLD:   ;
            default:   ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/nsqrt_dp.sv
// Estimate datapath: input latch, estimate register, pass counter, result.
module nsqrt_dp #(
    parameter int IN_W   = 16,
    parameter int RES_W  = 32,
    parameter int FRAC_W = 6,
    parameter int PASSES = 10
) (
    input  logic             clk,
    input  logic             run_en,
    input  logic [IN_W-1:0]  rad_in,
    input  logic             cap_input,
    input  logic             init_est,
    input  logic             upd_est,
    input  logic             publish,
    input  logic [RES_W-1:0] quot,
    output logic [RES_W-1:0] dividend,
    output logic [RES_W-1:0] est,
    output logic             rad_zero,
    output logic             last_pass,
    output logic [$clog2(PASSES+1)-1:0] pass_cnt,
    output logic [RES_W-1:0] root,
    output logic             valid
);
    localparam int SCALE_SH = 2 * FRAC_W;
    localparam int INIT_SH  = FRAC_W - 1;
    localparam int PW       = $clog2(PASSES + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(PASSES - 1);

    logic [IN_W-1:0]  rad_q;
    logic [RES_W-1:0] est_q;
    logic [PW-1:0]    pass_q;
    logic [RES_W-1:0] root_q;
    logic             valid_q;
    logic [RES_W:0]   sum;

    always_comb begin
        sum = {1'b0, est_q} + {1'b0, quot};
    end

    always_ff @(posedge clk) begin
        if (!run_en) begin
            rad_q   <= '0;
            est_q   <= '0;
            pass_q  <= '0;
            root_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (cap_input) begin
                rad_q <= rad_in;
            end
            if (init_est) begin
                est_q  <= RES_W'(rad_q) << INIT_SH;
                pass_q <= '0;
            end else if (upd_est) begin
                est_q  <= sum[RES_W:1];
                pass_q <= pass_q + 1'b1;
            end
            if (publish) begin
                root_q  <= est_q;
                valid_q <= 1'b1;
            end
        end
    end

    assign dividend  = RES_W'(rad_q) << SCALE_SH;
    assign est       = est_q;
    assign rad_zero  = (rad_q == '0);
    assign last_pass = (pass_q == LAST_IDX);
    assign pass_cnt  = pass_q;
    assign root      = root_q;
    assign valid     = valid_q;

endmodule

// File: rtl/nsqrt_top.sv
module nsqrt_top
    import nsqrt_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int RES_W  = 32,
    parameter int FRAC_W = 6,
    parameter int PASSES = 10
) (
    input  logic             clk,
    input  logic             run_en,
    input  logic [IN_W-1:0]  rad_in,
    output logic [RES_W-1:0] root_out,
    output logic             root_valid
);
    localparam int PW = $clog2(PASSES + 1);

    nsqrt_state_e     state;
    logic             cap_input;
    logic             init_est;
    logic             div_go;
    logic             upd_est;
    logic             publish;
    logic             rad_zero;
    logic             last_pass;
    logic             div_busy;
    logic             div_done;
    logic [RES_W-1:0] quot;
    logic [RES_W-1:0] dividend;
    logic [RES_W-1:0] est;
    logic [PW-1:0]    pass_cnt;

    nsqrt_ctrl ctrl_i (
        .clk       (clk),
        .run_en    (run_en),
        .rad_zero  (rad_zero),
        .div_done  (div_done),
        .last_pass (last_pass),
        .state     (state),
        .cap_input (cap_input),
        .init_est  (init_est),
        .div_go    (div_go),
        .upd_est   (upd_est),
        .publish   (publish)
    );

    nsqrt_dp #(
        .IN_W   (IN_W),
        .RES_W  (RES_W),
        .FRAC_W (FRAC_W),
        .PASSES (PASSES)
    ) dp_i (
        .clk       (clk),
        .run_en    (run_en),
        .rad_in    (rad_in),
        .cap_input (cap_input),
        .init_est  (init_est),
        .upd_est   (upd_est),
        .publish   (publish),
        .quot      (quot),
        .dividend  (dividend),
        .est       (est),
        .rad_zero  (rad_zero),
        .last_pass (last_pass),
        .pass_cnt  (pass_cnt),
        .root      (root_out),
        .valid     (root_valid)
    );

    nsqrt_divider #(
        .W (RES_W)
    ) div_i (
        .clk      (clk),
        .clear    (!run_en),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (est),
        .quotient (quot),
        .busy     (div_busy),
        .done     (div_done)
    );

endmodule

// File: rtl/nsqrt_checker.sv
module nsqrt_checker #(
    parameter int IN_W   = 16,
    parameter int RES_W  = 32,
    parameter int FRAC_W = 6,
    parameter int PASSES = 10
) (
    input logic             clk,
    input logic             run_en,
    input logic [RES_W-1:0] root_out,
    input logic             root_valid,
    input logic             div_go,
    input logic             div_busy,
    input logic [$clog2(PASSES+1)-1:0] pass_cnt
);
    localparam logic [RES_W-1:0] LIMIT = RES_W'(1) << (IN_W / 2 + FRAC_W);
    localparam int PW = $clog2(PASSES + 1);

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (!armed)
        !run_en |=> (!root_valid && root_out == '0)); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!run_en)
        root_valid |=> (root_valid && $stable(root_out))); // R6

    AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (!run_en)
        root_valid |-> (root_out <= LIMIT)); // R9

    AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!run_en)
        div_go |-> !div_busy); // R8

    AST_DIV_GOES_BUSY: assert property (@(posedge clk) disable iff (!run_en)
        div_go |=> div_busy); // R8

    AST_NOT_VALID_WHILE_DIVIDING: assert property (@(posedge clk) disable iff (!run_en)
        div_busy |-> !root_valid); // R5

    AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!run_en)
        pass_cnt <= PW'(PASSES)); // R4

endmodule

bind nsqrt_top nsqrt_checker #(
    .IN_W   (IN_W),
    .RES_W  (RES_W),
    .FRAC_W (FRAC_W),
    .PASSES (PASSES)
) chk_i (
    .clk        (clk),
    .run_en     (run_en),
    .root_out   (root_out),
    .root_valid (root_valid),
    .div_go     (div_go),
    .div_busy   (div_busy),
    .pass_cnt   (pass_cnt)
);

// File: tb/nsqrt_top_tb_top.sv
module nsqrt_top_tb_top;

    localparam int LAT_NZ = 342;
    localparam int LAT_Z  = 2;

    logic        clk = 1'b0;
    logic        run_en = 1'b0;
    logic [15:0] rad_in = '0;
    logic [31:0] root_out;
    logic        root_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    nsqrt_top dut_i (
        .clk        (clk),
        .run_en     (run_en),
        .rad_in     (rad_in),
        .root_out   (root_out),
        .root_valid (root_valid)
    );

    function automatic longint isq(input longint x);
        longint lo = 0;
        longint hi = 65536;
        while (hi - lo > 1) begin
            longint mid = (lo + hi) / 2;
            if (mid * mid <= x) lo = mid;
            else hi = mid;
        end
        return lo;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced at every rising edge and compared shortly after.
    bit     m_busy  = 1'b0;
    bit     m_valid = 1'b0;
    int     m_left  = 0;
    longint m_in    = 0;
    longint m_exp   = 0;

    always @(posedge clk) begin
        if (!run_en) begin
            m_busy  = 1'b0;
            m_valid = 1'b0;
        end else if (!m_busy && !m_valid) begin
            m_busy = 1'b1;
            m_in   = longint'(rad_in);
            m_exp  = isq(m_in * 4096);
            m_left = (rad_in == 0) ? LAT_Z : LAT_NZ;
        end else if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy  = 1'b0;
                m_valid = 1'b1;
            end
        end
        #2;
        if (root_valid !== m_valid) begin
            chk(1'b0, m_valid ? "R4 valid late" : "R5 valid early",
                longint'(root_valid), longint'(m_valid));
        end else if (m_valid) begin
            chk(root_out == m_exp || root_out == m_exp + 1,
                (m_in == 0) ? "R3 zero result" : "R1 root value",
                longint'(root_out), m_exp);
        end else begin
            chk(root_out == 0, "R7 result cleared", longint'(root_out), 0);
        end
    end

    task automatic run_one(input int n, input bit disturb);
        int     cnt = 0;
        int     lat = (n == 0) ? LAT_Z : LAT_NZ;
        longint ex  = isq(longint'(n) * 4096);
        logic [31:0] held;
        @(negedge clk);
        rad_in = 16'(n);
        run_en = 1'b1;
        do begin
            @(negedge clk);
            cnt++;
            if (disturb && cnt == 3) rad_in = ~16'(n);
        end while (!root_valid && cnt < 400);
        chk(cnt == lat + 1, "R4 R8 latency", cnt, lat + 1);
        if (disturb)
            chk(root_out == ex || root_out == ex + 1, "R2 input sampled once",
                longint'(root_out), ex);
        chk(root_out <= 32'd16384, "R9 bound", longint'(root_out), 16384);
        held = root_out;
        rad_in = 16'(n) ^ 16'h5a5a;
        repeat (5) @(negedge clk);
        chk(root_valid && root_out == held, "R6 hold", longint'(root_out), longint'(held));
        run_en = 1'b0;
        @(negedge clk);
        chk(!root_valid && root_out == 0, "R7 disable clears",
            longint'(root_valid), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(!root_valid && root_out == 0, "R7 reset state", longint'(root_out), 0);

        run_one(0, 1'b0);
        run_one(0, 1'b1);
        run_one(1, 1'b0);
        run_one(2, 1'b0);
        run_one(3, 1'b1);
        run_one(4, 1'b0);
        run_one(15, 1'b0);
        run_one(16, 1'b0);
        run_one(255, 1'b0);
        run_one(256, 1'b1);
        run_one(1024, 1'b0);
        run_one(9999, 1'b0);
        run_one(65534, 1'b0);
        run_one(65535, 1'b1);

        // Abort partway, then recover.
        @(negedge clk);
        rad_in = 16'd40000;
        run_en = 1'b1;
        repeat (100) @(negedge clk);
        chk(!root_valid, "R5 mid computation", longint'(root_valid), 0);
        run_en = 1'b0;
        @(negedge clk);
        chk(!root_valid && root_out == 0, "R7 abort", longint'(root_out), 0);
        run_one(9, 1'b0);

        for (int i = 3; i < 256; i += 3) begin
            run_one(i * i, 1'b0);
            if (i % 15 == 0) run_one(i * i - 1, 1'b0);
        end
        for (int k = 0; k < 60; k++) begin
            run_one((k * 2731 + 517) % 65536, k % 7 == 0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule